// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a parameterized number of source lines, which can be external pins or peripheral outputs. For each source, software selects an enable, the active polarity, level or edge sensing, and a 3-bit priority. The block tracks which sources are pending. It resolves the highest-priority pending source and presents the winner's level and vector to the processor. It raises a maskable request only when the processor's global enable is set and the winning level is above the processor's current mask level.

There is also a non-maskable path: a non-maskable input and a watchdog input reach a separate request output without passing through the enable or the mask. Each source can also drive its own DMA trigger line, either instead of the processor path or alongside it. A fixed subset of sources, selected by a parameter, drives a wake-up output for leaving low-power states.

Edge-sensed sources latch a pending bit. Software removes it by writing a source index to the clear port.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, `irq_req`, `irq_vec`, `irq_level`, `nmi_req`, `dma_trig` and `wake_out` are all zero.
- R2: A level-sensed source is active while its synchronized input equals its polarity (`cfg_pol` bit 1 = active high, 0 = active low). Outputs follow the input within four clock edges and drop when the input goes inactive.
- R3: For an edge-sensed source (`cfg_edge` bit = 1), an inactive-to-active transition sets a pending bit. That bit stays set after the input returns to inactive.
- R4: A pulse on `clr_valid` clears the pending bit of source `clr_idx` only. If an edge arrives on the same cycle, the edge wins.
- R5: The source considered is the one with the highest nonzero priority among the enabled, active sources that have `cfg_cpu` set. Priority of source i sits in `cfg_prio[3i+2:3i]`.
- R6: When two or more considered sources share the highest priority, the lowest source index wins.
- R7: A source whose enable bit is 0 or whose priority is 0 takes no part in requests, DMA triggers or wake-up.
- R8: `irq_req` is 1 only when `int_enable` is 1 and the winning priority is strictly greater than `mask_level`. `irq_vec` and `irq_level` show the winner whatever the mask.
- R9: `irq_vec` equals the winning source index shifted left by two (bits [1:0] are zero). `irq_vec` and `irq_level` are zero when no source is considered.
- R10: `nmi_req` is the registered OR of `nmi_in` and `wdt_in`. It does not depend on `int_enable` or `mask_level`.
- R11: Bit i of `dma_trig` is set when source i is enabled, active, has nonzero priority and has `cfg_dma` bit i set. A source with `cfg_cpu` bit i at 0 still drives its DMA trigger but never wins the processor request.
- R12: `wake_out` is set when any enabled, active source with nonzero priority lies in `WAKE_MASK` (default: sources 0 to 5). Sources outside that mask never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Raw interrupt source lines |
| cfg_en | input | NSRC | Per-source enable |
| cfg_pol | input | NSRC | Per-source polarity, 1 = active high |
| cfg_edge | input | NSRC | Per-source sensing, 1 = edge, 0 = level |
| cfg_prio | input | 3*NSRC | Per-source priority, 0 = off |
| cfg_cpu | input | NSRC | Source may raise the processor request |
| cfg_dma | input | NSRC | Source drives its DMA trigger |
| mask_level | input | 3 | Processor mask level |
| int_enable | input | 1 | Processor global interrupt enable |
| nmi_in | input | 1 | Non-maskable interrupt input |
| wdt_in | input | 1 | Watchdog interrupt input |
| clr_valid | input | 1 | Clear strobe |
| clr_idx | input | $clog2(NSRC) | Index of the source to clear |
| irq_req | output | 1 | Maskable request to the processor |
| irq_vec | output | $clog2(NSRC)+2 | Vector of the winning source |
| irq_level | output | 3 | Priority of the winning source |
| nmi_req | output | 1 | Non-maskable request |
| dma_trig | output | NSRC | Per-source DMA triggers |
| wake_out | output | 1 | Wake-up signal |

## Verification
The bench targets these corners:
- **Priority tie between two sources.** A resolver that compared with greater-or-equal would hand the vector to the higher index.
- **Winner level equal to the mask.** An off-by-one in the mask compare would raise a request there.
- **Edge source after its input has dropped.** A controller that did not latch edges would lose the request.
- **Clear aimed at a different index.** A decoder that ignored the index would wipe the wrong pending bit.

It also checks that a DMA-only source triggers without stealing the processor vector. It checks that an active-low line requests only when driven low. Finally, it checks that a source outside the wake subset leaves the wake output low while a source inside it raises it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned PRIO_W    = 3;
    localparam int unsigned VEC_SHIFT = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    function automatic prio_t prio_of(input logic [PRIO_W-1:0] field);
        return prio_t'(field);
    endfunction
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC  = 16,
    parameter int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_in,
    input  logic [NSRC-1:0]  cfg_pol,
    input  logic [NSRC-1:0]  cfg_edge,
    input  logic             clr_valid,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  src_active
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic   sync1, sync2, prev, pend;
        logic   lvl_now, lvl_old, rise, clr_hit;
        sense_e mode;

        assign mode    = sense_e'(cfg_edge[i]);
        assign lvl_now = cfg_pol[i] ? sync2 : ~sync2;
        assign lvl_old = cfg_pol[i] ? prev  : ~prev;
        assign rise    = lvl_now & ~lvl_old;
        assign clr_hit = clr_valid && (clr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                sync1 <= 1'b0;
                sync2 <= 1'b0;
                prev  <= 1'b0;
                pend  <= 1'b0;
            end else begin
                sync1 <= src_in[i];
                sync2 <= sync1;
                prev  <= sync2;
                if (mode != SENSE_EDGE)
                    pend <= 1'b0;
                else if (rise)
                    pend <= 1'b1;
                else if (clr_hit)
                    pend <= 1'b0;
            end
        end

        assign src_active[i] = (mode == SENSE_EDGE) ? pend : lvl_now;

        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
            (pend && mode == SENSE_EDGE && !clr_hit) |=> pend); // R3
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_hit && !rise) |=> !pend); // R4
    end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC  = 16,
    parameter int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output prio_t                  win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && prio_of(prio_flat[i*PRIO_W +: PRIO_W]) > win_prio) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_of(prio_flat[i*PRIO_W +: PRIO_W]);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned     NSRC      = 16,
    parameter logic [NSRC-1:0] WAKE_MASK = NSRC'('h3F),
    localparam int unsigned    IDX_W     = $clog2(NSRC),
    localparam int unsigned    VEC_W     = IDX_W + VEC_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        src_in,
    input  logic [NSRC-1:0]        cfg_en,
    input  logic [NSRC-1:0]        cfg_pol,
    input  logic [NSRC-1:0]        cfg_edge,
    input  logic [NSRC*PRIO_W-1:0] cfg_prio,
    input  logic [NSRC-1:0]        cfg_cpu,
    input  logic [NSRC-1:0]        cfg_dma,
    input  logic [PRIO_W-1:0]      mask_level,
    input  logic                   int_enable,
    input  logic                   nmi_in,
    input  logic                   wdt_in,
    input  logic                   clr_valid,
    input  logic [IDX_W-1:0]       clr_idx,
    output logic                   irq_req,
    output logic [VEC_W-1:0]       irq_vec,
    output logic [PRIO_W-1:0]      irq_level,
    output logic                   nmi_req,
    output logic [NSRC-1:0]        dma_trig,
    output logic                   wake_out
);
    logic [NSRC-1:0]  src_active, armed, live, cand;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    prio_t            win_prio;

    irqc_detect #(.NSRC(NSRC), .IDX_W(IDX_W)) u_detect (
        .clk(clk), .rst(rst), .src_in(src_in), .cfg_pol(cfg_pol),
        .cfg_edge(cfg_edge), .clr_valid(clr_valid), .clr_idx(clr_idx),
        .src_active(src_active)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_arm
        assign armed[i] = cfg_en[i] && (cfg_prio[i*PRIO_W +: PRIO_W] != '0);
    end

    assign live = armed & src_active;
    assign cand = live & cfg_cpu;

    irqc_resolve #(.NSRC(NSRC), .IDX_W(IDX_W)) u_resolve (
        .cand(cand), .prio_flat(cfg_prio),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req   <= 1'b0;
            irq_vec   <= '0;
            irq_level <= '0;
            nmi_req   <= 1'b0;
            dma_trig  <= '0;
            wake_out  <= 1'b0;
        end else begin
            irq_req   <= win_valid && int_enable && (win_prio > mask_level);
            irq_vec   <= win_valid ? {win_idx, VEC_SHIFT'(0)} : '0;
            irq_level <= win_valid ? win_prio : '0;
            nmi_req   <= nmi_in | wdt_in;
            dma_trig  <= live & cfg_dma;
            wake_out  <= |(live & WAKE_MASK);
        end
    end

    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !$past(rst)) |-> ($past(int_enable) && irq_level > $past(mask_level))); // R8
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        irq_vec[VEC_SHIFT-1:0] == '0); // R9
    AST_NO_WINNER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (irq_level == '0) |-> (irq_vec == '0 && !irq_req)); // R9
    AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(nmi_in) || $past(wdt_in))) |-> nmi_req); // R10
    AST_DMA_CONFIGURED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((dma_trig & ~$past(cfg_dma)) == '0)); // R11
    AST_WAKE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past((src_active & WAKE_MASK) == '0)) |-> !wake_out); // R12
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int NSRC  = 16;
    localparam int IDX_W = 4;
    localparam int VEC_W = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic [NSRC-1:0]   src_in, cfg_en, cfg_pol, cfg_edge, cfg_cpu, cfg_dma;
    logic [NSRC*3-1:0] cfg_prio;
    logic [2:0]        mask_level;
    logic              int_enable, nmi_in, wdt_in, clr_valid;
    logic [IDX_W-1:0]  clr_idx;
    logic              irq_req, nmi_req, wake_out;
    logic [VEC_W-1:0]  irq_vec;
    logic [2:0]        irq_level;
    logic [NSRC-1:0]   dma_trig;

    always #10 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .cfg_en(cfg_en), .cfg_pol(cfg_pol),
        .cfg_edge(cfg_edge), .cfg_prio(cfg_prio), .cfg_cpu(cfg_cpu), .cfg_dma(cfg_dma),
        .mask_level(mask_level), .int_enable(int_enable), .nmi_in(nmi_in),
        .wdt_in(wdt_in), .clr_valid(clr_valid), .clr_idx(clr_idx),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_level(irq_level),
        .nmi_req(nmi_req), .dma_trig(dma_trig), .wake_out(wake_out)
    );

    typedef struct {
        bit    req;
        int    vec;
        int    lvl;
        bit    nmi;
        int    dma;
        bit    wake;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (irq_req !== e.req || int'(irq_vec) != e.vec || int'(irq_level) != e.lvl ||
                    nmi_req !== e.nmi || int'(dma_trig) != e.dma || wake_out !== e.wake) begin
                    errors++;
                    $display("FAIL %s: actual req=%0b vec=%0d lvl=%0d nmi=%0b dma=%h wake=%0b expected req=%0b vec=%0d lvl=%0d nmi=%0b dma=%h wake=%0b",
                             e.tag, irq_req, irq_vec, irq_level, nmi_req, dma_trig, wake_out,
                             e.req, e.vec, e.lvl, e.nmi, e.dma, e.wake);
                end
            end
        end
    end

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic expect_out(input bit req, input int vec, input int lvl, input bit nmi,
                              input int dma, input bit wake, input string tag);
        exp_t e;
        e.req = req; e.vec = vec; e.lvl = lvl; e.nmi = nmi;
        e.dma = dma; e.wake = wake; e.tag = tag;
        q.push_back(e);
        while (q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int idx, input int p);
        cfg_prio[idx*3 +: 3] = 3'(p);
    endtask

    task automatic defaults();
        src_in = '0; cfg_en = '1; cfg_pol = '1; cfg_edge = '0; cfg_prio = '0;
        cfg_cpu = '1; cfg_dma = '0; mask_level = '0; int_enable = 1'b1;
        nmi_in = 1'b0; wdt_in = 1'b0; clr_valid = 1'b0; clr_idx = '0;
    endtask

    task automatic pulse_clear(input int idx);
        clr_idx = IDX_W'(idx); clr_valid = 1'b1;
        @(negedge clk);
        clr_valid = 1'b0;
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        defaults();
        rst = 1'b1;
        src_in = '1; nmi_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_out(0, 0, 0, 0, 0, 0, "R1 outputs during reset");
        src_in = '0; nmi_in = 1'b0;
        rst = 1'b0;
        settle();
        expect_out(0, 0, 0, 0, 0, 0, "R1 idle after reset");

        // R2/R9/R12: active-high level source 3 (inside wake subset)
        set_prio(3, 4); src_in[3] = 1'b1; settle();
        expect_out(1, 12, 4, 0, 0, 1, "R2 R9 level high src3");
        src_in[3] = 1'b0; settle();
        expect_out(0, 0, 0, 0, 0, 0, "R2 level src3 released");

        // R2 active-low source 9 (outside wake subset)
        set_prio(9, 2); cfg_pol[9] = 1'b0; src_in[9] = 1'b1; settle();
        expect_out(0, 0, 0, 0, 0, 0, "R2 active-low idle high");
        src_in[9] = 1'b0; settle();
        expect_out(1, 36, 2, 0, 0, 0, "R2 R12 active-low driven");

        // R5: higher priority wins
        src_in[3] = 1'b1; settle();
        expect_out(1, 12, 4, 0, 0, 1, "R5 higher level wins");
        src_in[3] = 1'b0;

        // R6: tie goes to lower index
        set_prio(12, 2); src_in[12] = 1'b1; settle();
        expect_out(1, 36, 2, 0, 0, 0, "R6 tie lower index");

        // R8: mask compare and global enable
        mask_level = 3'd2; settle();
        expect_out(0, 36, 2, 0, 0, 0, "R8 level equal mask");
        mask_level = 3'd1; settle();
        expect_out(1, 36, 2, 0, 0, 0, "R8 level above mask");
        int_enable = 1'b0; settle();
        expect_out(0, 36, 2, 0, 0, 0, "R8 global enable off");

        defaults(); settle();
        expect_out(0, 0, 0, 0, 0, 0, "R2 all released");

        // R7: disabled or zero priority ignored
        set_prio(7, 5); cfg_en[7] = 1'b0; src_in[7] = 1'b1; settle();
        expect_out(0, 0, 0, 0, 0, 0, "R7 enable off");
        cfg_en[7] = 1'b1; set_prio(7, 0); cfg_dma[7] = 1'b1; settle();
        expect_out(0, 0, 0, 0, 0, 0, "R7 priority zero");
        set_prio(7, 5); cfg_dma[7] = 1'b0; settle();
        expect_out(1, 28, 5, 0, 0, 0, "R7 armed src7");
        src_in[7] = 1'b0; settle();

        // R3/R4: edge source 10
        cfg_edge[10] = 1'b1; set_prio(10, 3); settle();
        src_in[10] = 1'b1; repeat (3) @(negedge clk);
        src_in[10] = 1'b0; settle();
        expect_out(1, 40, 3, 0, 0, 0, "R3 edge latched after drop");
        pulse_clear(11);
        expect_out(1, 40, 3, 0, 0, 0, "R4 clear other index");
        pulse_clear(10);
        expect_out(0, 0, 0, 0, 0, 0, "R4 clear own index");

        // R10: non-maskable path
        int_enable = 1'b0; mask_level = 3'd7; nmi_in = 1'b1; settle();
        expect_out(0, 0, 0, 1, 0, 0, "R10 nmi unmasked");
        nmi_in = 1'b0; wdt_in = 1'b1; settle();
        expect_out(0, 0, 0, 1, 0, 0, "R10 watchdog unmasked");
        wdt_in = 1'b0; settle();
        expect_out(0, 0, 0, 0, 0, 0, "R10 released");

        // R11: DMA-only source
        defaults();
        set_prio(2, 6); cfg_cpu[2] = 1'b0; cfg_dma[2] = 1'b1; src_in[2] = 1'b1; settle();
        expect_out(0, 0, 0, 0, 'h4, 1, "R11 dma only");
        cfg_cpu[2] = 1'b1; settle();
        expect_out(1, 8, 6, 0, 'h4, 1, "R11 dma and cpu");
        defaults(); settle();

        // R12: wake subset
        set_prio(6, 1); src_in[6] = 1'b1; settle();
        expect_out(1, 24, 1, 0, 0, 0, "R12 src6 outside subset");
        set_prio(5, 1); src_in[5] = 1'b1; settle();
        expect_out(1, 20, 1, 0, 0, 1, "R12 src5 inside subset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule